// File: doc/BRIEF.md
# Noise-Tolerant Unsigned Multiplier with Reduced-Precision Checker

This block multiplies two unsigned operands with a full-precision main array and, in parallel, forms a cheap fixed-width estimate of the upper part of the same product. The estimate is used as a reference. When the main result strays from the scaled estimate by more than a threshold supplied with the sample, the estimate is output instead and an error flag is raised. This guards against timing failures in an aggressively clocked or under-powered main array. A fault mask input lets a test environment corrupt the main result on purpose.

The estimate uses only the upper halves of both operands. It keeps the partial products whose column weight is at least 3H, where H = W/2. It then adds a correction taken from the two columns just below that boundary. The estimate is H bits wide and is shifted left by 3H to line up with the 2W-bit product.

Samples enter on a valid/ready handshake and leave on a second one. There is a single register stage. A sample accepted at a clock edge is presented at the output from that same edge. The output holds while the consumer withholds ready. The input is ready whenever the output register is empty or is being drained in the same cycle, so full throughput needs no bubble.

Top module: `ant_mult_top`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `out_main` equals the exact 2W-bit unsigned product `in_a*in_b` XOR `in_fault`, taken from the accepted sample.
- R3: `out_replica` is an H-bit value built from bits H..W-1 of both operands. Take every bit product `a[i]&b[j]` with i+j >= 3H, weighted by 2^(i+j-3H). Add beta, the count of bit products with i+j = 3H-1. Add 1 more when beta is 0 and any bit product with i+j = 3H-2 is 1. This sum never exceeds 2^H-1.
- R4: Let D = |out_main - (out_replica << 3H)|, formed in 2W+1 bits with no wraparound. When D > threshold (strictly greater), `out_product` is `out_replica << 3H` and `out_err` is 1. Otherwise `out_product` is `out_main` and `out_err` is 0. D equal to the threshold is not an error.
- R5: The fault mask acts before the comparison. With a zero mask and a threshold no smaller than the largest error-free D, `out_product` is the exact product and `out_err` is 0.
- R6: A sample accepted when `in_valid` and `in_ready` are both 1 at a rising edge appears with `out_valid` = 1 right after that edge.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and all outputs hold their values.
- R8: When the output is drained (`out_valid` and `out_ready` both 1) and `in_valid` is 0, `out_valid` is 0 after that edge.
- R9: `in_thresh` and `in_fault` are captured together with the operands and apply only to that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_a | input | W | Multiplicand, unsigned |
| in_b | input | W | Multiplier, unsigned |
| in_thresh | input | 2W | Largest tolerated main/estimate distance |
| in_fault | input | 2W | Mask XORed into the main product |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_product | output | 2W | Selected product |
| out_err | output | 1 | Estimate substituted for the main result |
| out_main | output | 2W | Main result after the mask |
| out_replica | output | W/2 | Fixed-width estimate, unscaled |

## Verification
Two things can happen in the same clock edge: the output register is drained, and a new sample, possibly carrying a fault mask that forces substitution, is loaded. The bench stalls the consumer with a sample pending and keeps a second sample waiting at the input. It then raises ready. The held value must stay frozen during the stall. The waiting sample must be loaded at the edge where the old one leaves, and its selected product and error flag must match the arithmetic model. Exhaustive operand sweeps at a 6-bit width run under three settings: an open threshold, a zero threshold, and a top-bit fault with the tightest error-free threshold. These sweeps judge the selection rule. Equal-distance probes pin down the strict comparison.

// File: rtl/ant_mult_pkg.sv
package ant_mult_pkg;

  // Which source drives the selected product.
  typedef enum logic {
    SRC_MAIN    = 1'b0,
    SRC_REPLICA = 1'b1
  } ant_src_e;

  // Lowest kept column of the fixed-width estimate for an operand width w.
  function automatic int keep_col(input int w);
    return 3 * (w / 2);
  endfunction

endpackage

// File: rtl/ant_main_mult.sv
module ant_main_mult #(
  parameter int W = 12
) (
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic [PW-1:0] rows [W];

  // One shifted partial-product row per multiplier bit.
  for (genvar j = 0; j < W; j++) begin : g_row
    assign rows[j] = op_b[j] ? ({{W{1'b0}}, op_a} << j) : '0;
  end

  always_comb begin
    prod = '0;
    for (int j = 0; j < W; j++) begin
      prod = prod + rows[j];
    end
  end
endmodule

// File: rtl/ant_replica_mult.sv
module ant_replica_mult #(
  parameter int W = 12
) (
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [W/2-1:0] est,
  output logic           est_ovf
);
  import ant_mult_pkg::*;

  localparam int H    = W / 2;
  localparam int KEEP = keep_col(W);

  logic [H:0] msp_sum;
  logic [H:0] beta;
  logic       minor_any;
  logic       boost;
  logic [H:0] total;

  // Kept columns, main correction count and minor correction flag.
  always_comb begin
    msp_sum   = '0;
    beta      = '0;
    minor_any = 1'b0;
    for (int i = H; i < W; i++) begin
      for (int j = H; j < W; j++) begin
        if (i + j >= KEEP) begin
          msp_sum = msp_sum + ((H+1)'(op_a[i] & op_b[j]) << (i + j - KEEP));
        end else if (i + j == KEEP - 1) begin
          beta = beta + (H+1)'(op_a[i] & op_b[j]);
        end else if (i + j == KEEP - 2) begin
          minor_any = minor_any | (op_a[i] & op_b[j]);
        end
      end
    end
  end

  assign boost   = (beta == '0) && minor_any;
  assign total   = msp_sum + beta + (H+1)'(boost);
  assign est     = total[H-1:0];
  assign est_ovf = total[H];
endmodule

// File: rtl/ant_err_select.sv
module ant_err_select #(
  parameter int W = 12
) (
  input  logic [2*W-1:0] main_val,
  input  logic [2*W-1:0] ref_val,
  input  logic [2*W-1:0] limit,
  output logic [2*W-1:0] chosen,
  output logic           flagged
);
  import ant_mult_pkg::*;

  localparam int PW = 2 * W;

  logic [PW:0] delta;
  logic [PW:0] mag;
  ant_src_e    src;

  // One extra bit keeps the signed distance from wrapping.
  assign delta = {1'b0, main_val} - {1'b0, ref_val};
  assign mag   = delta[PW] ? (~delta + 1'b1) : delta;
  assign src   = (mag > {1'b0, limit}) ? SRC_REPLICA : SRC_MAIN;

  assign chosen  = (src == SRC_REPLICA) ? ref_val : main_val;
  assign flagged = (src == SRC_REPLICA);
endmodule

// File: rtl/ant_mult_top.sv
module ant_mult_top #(
  parameter int W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic [2*W-1:0]   in_thresh,
  input  logic [2*W-1:0]   in_fault,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2*W-1:0]   out_product,
  output logic             out_err,
  output logic [2*W-1:0]   out_main,
  output logic [W/2-1:0]   out_replica
);
  import ant_mult_pkg::*;

  localparam int H    = W / 2;
  localparam int PW   = 2 * W;
  localparam int KEEP = keep_col(W);

  logic [PW-1:0] main_prod;
  logic [PW-1:0] main_faulty;
  logic [H-1:0]  rep_est;
  logic          rep_ovf;
  logic [PW-1:0] rep_full;
  logic [PW-1:0] sel_val;
  logic          sel_err;
  logic          take;

  ant_main_mult #(.W(W)) u_main (
    .op_a (in_a),
    .op_b (in_b),
    .prod (main_prod)
  );

  ant_replica_mult #(.W(W)) u_rep (
    .op_a    (in_a),
    .op_b    (in_b),
    .est     (rep_est),
    .est_ovf (rep_ovf)
  );

  assign main_faulty = main_prod ^ in_fault;
  assign rep_full    = {rep_est, {KEEP{1'b0}}};

  ant_err_select #(.W(W)) u_sel (
    .main_val (main_faulty),
    .ref_val  (rep_full),
    .limit    (in_thresh),
    .chosen   (sel_val),
    .flagged  (sel_err)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_product <= '0;
      out_err     <= 1'b0;
      out_main    <= '0;
      out_replica <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (take) begin
        out_product <= sel_val;
        out_err     <= sel_err;
        out_main    <= main_faulty;
        out_replica <= rep_est;
      end
    end
  end
endmodule

// File: rtl/ant_mult_chk.sv
module ant_mult_chk #(
  parameter int W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [2*W-1:0]   out_product,
  input logic             out_err,
  input logic [2*W-1:0]   out_main,
  input logic [W/2-1:0]   out_replica,
  input logic             rep_ovf
);
  localparam int KEEP = 3 * (W / 2);

  p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_product)
      && $stable(out_err) && $stable(out_main) && $stable(out_replica));

  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  p_sel_rep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_product == {out_replica, {KEEP{1'b0}}});

  p_sel_main_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> out_product == out_main);

  p_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !rep_ovf);
endmodule

bind ant_mult_top ant_mult_chk #(.W(W)) i_chk (.*);

// File: tb/test_ant_mult_top.sv
module test_ant_mult_top;
  localparam int TW   = 6;
  localparam int TH   = TW / 2;
  localparam int TP   = 2 * TW;
  localparam int KEEP = 3 * TH;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [TW-1:0] in_a = '0;
  logic [TW-1:0] in_b = '0;
  logic [TP-1:0] in_thresh = '0;
  logic [TP-1:0] in_fault = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [TP-1:0] out_product;
  logic          out_err;
  logic [TP-1:0] out_main;
  logic [TH-1:0] out_replica;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  ant_mult_top #(.W(TW)) i_ant_mult_top (
    .clk, .rst_n, .in_valid, .in_ready, .in_a, .in_b, .in_thresh, .in_fault,
    .out_valid, .out_ready, .out_product, .out_err, .out_main, .out_replica
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Arithmetic model of the fixed-width estimate.
  function automatic int ref_est(input int a, input int b);
    int msp = 0;
    int beta = 0;
    int minor = 0;
    for (int i = TH; i < TW; i++) begin
      for (int j = TH; j < TW; j++) begin
        int bp = ((a >> i) & 1) * ((b >> j) & 1);
        if (i + j >= KEEP) msp += bp << (i + j - KEEP);
        else if (i + j == KEEP - 1) beta += bp;
        else if (i + j == KEEP - 2) minor |= bp;
      end
    end
    return msp + beta + ((beta == 0 && minor != 0) ? 1 : 0);
  endfunction

  function automatic int absd(input int x, input int y);
    return (x > y) ? x - y : y - x;
  endfunction

  task automatic step(input int a, input int b, input int th, input int m);
    in_a      = TW'(a);
    in_b      = TW'(b);
    in_thresh = TP'(th);
    in_fault  = TP'(m);
    in_valid  = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic judge(input int a, input int b, input int th, input int m, input string tag);
    int mval = (a * b) ^ m;
    int rf   = ref_est(a, b) << KEEP;
    bit e    = absd(mval, rf) > th;
    chk(out_valid == 1'b1, "R6 valid", out_valid, 1);
    chk(out_main == TP'(mval), "R2 main", out_main, mval);
    chk(out_err == e, {"R4 flag ", tag}, out_err, e);
    chk(out_product == TP'(e ? rf : mval), {"R4 product ", tag}, out_product, e ? rf : mval);
  endtask

  initial begin
    int thmax = 0;
    int pa = -1;
    int pb = -1;
    int d;
    int lim;
    lim = (1 << TP) - 1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid low", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid low", out_valid, 0);
    chk(in_ready == 1'b1, "R1 ready high", in_ready, 1);

    // Open threshold, no fault: exact product and correct estimate.
    for (int a = 0; a < (1 << TW); a++) begin
      for (int b = 0; b < (1 << TW); b++) begin
        int rf;
        step(a, b, lim, 0);
        rf = ref_est(a, b) << KEEP;
        if (absd(a * b, rf) > thmax) thmax = absd(a * b, rf);
        if (pa < 0 && absd(a * b, rf) > 1) begin pa = a; pb = b; end
        chk(out_replica == TH'(ref_est(a, b)), "R3 estimate", out_replica, ref_est(a, b));
        chk(out_product == TP'(a * b) && !out_err, "R5 exact product", out_product, a * b);
        chk(out_valid == 1'b1, "R6 valid", out_valid, 1);
      end
    end

    // Zero threshold: any distance substitutes.
    for (int a = 0; a < (1 << TW); a++)
      for (int b = 0; b < (1 << TW); b++) begin
        step(a, b, 0, 0);
        judge(a, b, 0, 0, "zero threshold");
      end

    // Top-bit fault under the tightest error-free threshold.
    for (int a = 0; a < (1 << TW); a++)
      for (int b = 0; b < (1 << TW); b++) begin
        step(a, b, thmax, 1 << (TP - 1));
        judge(a, b, thmax, 1 << (TP - 1), "fault R5");
        chk(out_err == 1'b1, "R5 fault replaced", out_err, 1);
      end

    // Strict comparison at equal distance; per-sample threshold (R9).
    d = absd(pa * pb, ref_est(pa, pb) << KEEP);
    step(pa, pb, d, 0);
    chk(out_err == 1'b0, "R4 equal distance", out_err, 0);
    step(pa, pb, d - 1, 0);
    chk(out_err == 1'b1, "R4 one below", out_err, 1);
    step(pa, pb, d, 0);
    chk(out_err == 1'b0, "R9 threshold per sample", out_err, 0);
    step(pa, pb, lim, 3);
    chk(out_main == TP'((pa * pb) ^ 3), "R9 mask per sample", out_main, (pa * pb) ^ 3);
    step(pa, pb, lim, 0);
    chk(out_main == TP'(pa * pb), "R9 mask cleared", out_main, pa * pb);

    // Stall with a waiting sample, then drain and load in one edge.
    in_valid = 1'b0;
    @(negedge clk);
    out_ready = 1'b0;
    step(45, 51, 0, 0);
    judge(45, 51, 0, 0, "stall entry");
    chk(in_ready == 1'b0, "R7 ready low", in_ready, 0);
    in_a = TW'(63); in_b = TW'(62); in_fault = TP'(1 << (TP - 1)); in_thresh = TP'(thmax);
    repeat (3) @(negedge clk);
    chk(out_main == TP'(45 * 51), "R7 held", out_main, 45 * 51);
    chk(in_ready == 1'b0, "R7 ready low", in_ready, 0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    judge(63, 62, thmax, 1 << (TP - 1), "drain and load R7");
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 drained", out_valid, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule